// File: doc/BRIEF.md
# Rotating Line Store for a 3x3 Window

This block turns one serial stream of pixels into three rows offered side by side, which is the input a 3x3 convolution stage needs. It keeps four line memories. One of them takes the incoming pixels. The other three hold complete lines and are read out together, one column per read. Because filling the fourth line overlaps with reading the current three, a new row of the image is ready as soon as the current one has been consumed.

When the window moves down one image row, only the oldest line is given up. The two lines that carry over are not loaded again. Their read counters go back to column 0 and they are read a second time, while the freed memory becomes the next write target. A write pointer and a read-base pointer, both taken modulo four, steer the write data and the three read outputs. An occupancy count relates the two pointers and drives the ready and full flags.

Top module: `rot_line_buf`

## Requirements
- R1: While `rst_n` is low, and after it is released, `lines_ready`, `all_read`, `wr_full` and `rd_valid` are 0 and no line is held. The first three lines written after reset form the first window.
- R2: A pixel is accepted on a cycle with `wen` high and `wr_full` low. Accepted pixels fill lines of `LINE_LEN` pixels in arrival order. Writing continues while the window is being read.
- R3: `lines_ready` is 1 exactly when at least three complete lines are held, counting from the window's oldest line.
- R4: A cycle with `ren` high, `lines_ready` high and `all_read` low reads column c. On the next cycle `rd_valid` is 1, and `row_top`, `row_mid` and `row_bot` carry column c of the oldest, middle and newest line of the window. Column c starts at 0 and rises by one per read.
- R5: After `LINE_LEN` reads of a window, `all_read` is 1. Further `ren` pulses give no `rd_valid` until the window moves.
- R6: `wr_full` is 1 when four complete lines are held, so the next write would land on the window's oldest line. `wen` has no effect while `wr_full` is 1.
- R7: On a cycle with `all_read` and `wr_full` both high, the window moves down one line at the next clock edge. `all_read` and `wr_full` go low, and reads restart at column 0. The two lines that carry over return their stored pixels again without being rewritten.
- R8: Pointers wrap modulo four, so streaming any number of lines keeps line order and pixel values intact.
- R9: `ren` has no effect while `lines_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| wen | input | 1 | Write strobe for one pixel |
| wdata | input | PIX_W | Pixel written when accepted |
| ren | input | 1 | Read strobe for one column of the window |
| row_top | output | PIX_W | Column value from the oldest window line |
| row_mid | output | PIX_W | Column value from the middle window line |
| row_bot | output | PIX_W | Column value from the newest window line |
| rd_valid | output | 1 | Row outputs carry a read result this cycle |
| lines_ready | output | 1 | Three complete lines are available for reading |
| all_read | output | 1 | Every column of the current window has been read |
| wr_full | output | 1 | Writes are stalled because all four lines are held |

## Verification
The bench builds the block with `LINE_LEN` of 8 and the default 8-bit pixels. With lines this short, full pointer wraps, many window moves, full stalls and the reuse of carried-over lines all fit into a few thousand cycles. A behavioural model indexes every accepted pixel by its global position in the stream. Any misrouted line or pointer error therefore shows up as a wrong row value, even after many rotations and after a reset in the middle of the stream.

// File: rtl/rlb_pkg.sv
package rlb_pkg;

  localparam int unsigned NLINES = 4;
  localparam int unsigned NTAPS  = 3;
  localparam int unsigned PTR_W  = $clog2(NLINES);
  localparam int unsigned OCC_W  = PTR_W + 1;

  typedef logic [PTR_W-1:0]  lptr_t;
  typedef logic [NLINES-1:0] lmask_t;
  typedef logic [OCC_W-1:0]  occ_t;

  function automatic lptr_t ptr_add(lptr_t p, int unsigned k);
    return lptr_t'((32'(p) + k) % NLINES);
  endfunction

  function automatic lmask_t span_mask(lptr_t base, int unsigned span);
    lmask_t m;
    m = '0;
    for (int unsigned j = 0; j < span; j++) begin
      m[ptr_add(base, j)] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/rlb_line_store.sv
module rlb_line_store #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned DEPTH = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PIX_W-1:0] wr_data,
  output logic             wr_last,
  input  logic             rd_en,
  input  logic             rd_rst,
  output logic [PIX_W-1:0] rd_data,
  output logic             rd_done
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [PIX_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_addr_q, wr_addr_d;
  logic [AW-1:0]    rd_addr_q, rd_addr_d;
  logic             done_q, done_d;
  logic             rd_take;
  logic [PIX_W-1:0] rd_data_q;

  // next-state logic
  always_comb begin
    wr_last   = wr_en && (wr_addr_q == LAST);
    wr_addr_d = wr_addr_q;
    if (wr_en) begin
      wr_addr_d = wr_last ? '0 : wr_addr_q + 1'b1;
    end

    rd_take   = rd_en && !done_q;
    rd_addr_d = rd_addr_q;
    done_d    = done_q;
    if (rd_rst || wr_last) begin
      rd_addr_d = '0;
      done_d    = 1'b0;
    end else if (rd_take) begin
      if (rd_addr_q == LAST) begin
        rd_addr_d = '0;
        done_d    = 1'b1;
      end else begin
        rd_addr_d = rd_addr_q + 1'b1;
      end
    end
  end

  // address and flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      rd_addr_q <= '0;
      done_q    <= 1'b0;
    end else begin
      wr_addr_q <= wr_addr_d;
      rd_addr_q <= rd_addr_d;
      done_q    <= done_d;
    end
  end

  // storage array, no reset on contents
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr_q] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_take) begin
      rd_data_q <= mem[rd_addr_q];
    end
  end

  assign rd_data = rd_data_q;
  assign rd_done = done_q;

endmodule

// File: rtl/rlb_ptr_ctrl.sv
module rlb_ptr_ctrl
  import rlb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wen,
  input  logic   ren,
  input  lmask_t wr_last_vec,
  input  lmask_t done_vec,
  output lptr_t  wr_ptr,
  output lptr_t  rd_ptr,
  output occ_t   held,
  output lmask_t wr_en_vec,
  output lmask_t rd_en_vec,
  output lmask_t rd_rst_vec,
  output logic   rd_go,
  output logic   lines_ready,
  output logic   wr_full,
  output logic   all_read
);

  lptr_t  wr_ptr_q, wr_ptr_d;
  lptr_t  rd_ptr_q, rd_ptr_d;
  occ_t   held_q, held_d;
  lmask_t rd_mask;
  logic   wr_go;
  logic   line_done;
  logic   advance;

  always_comb begin
    lines_ready = (held_q >= occ_t'(NTAPS));
    wr_full     = (held_q == occ_t'(NLINES));
    rd_mask     = span_mask(rd_ptr_q, NTAPS);
    all_read    = lines_ready && ((done_vec & rd_mask) == rd_mask);
    rd_go       = ren && lines_ready && !all_read;
    wr_go       = wen && !wr_full;
    wr_en_vec   = wr_go ? (lmask_t'(1) << wr_ptr_q) : '0;
    rd_en_vec   = rd_go ? rd_mask : '0;
    line_done   = |wr_last_vec;
    advance     = all_read && wr_full;
    // lines that stay in the window are rewound to column 0
    rd_rst_vec  = advance ? span_mask(ptr_add(rd_ptr_q, 1), NTAPS - 1) : '0;

    wr_ptr_d = line_done ? ptr_add(wr_ptr_q, 1) : wr_ptr_q;
    rd_ptr_d = advance   ? ptr_add(rd_ptr_q, 1) : rd_ptr_q;
    held_d   = held_q;
    if (line_done) begin
      held_d = held_q + 1'b1;
    end else if (advance) begin
      held_d = held_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      held_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      held_q   <= held_d;
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
  assign held   = held_q;

endmodule

// File: rtl/rlb_row_mux.sv
module rlb_row_mux
  import rlb_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_go,
  input  lptr_t                        rd_ptr,
  input  logic [NLINES-1:0][PIX_W-1:0] store_data,
  output logic                         rd_valid,
  output logic [NTAPS-1:0][PIX_W-1:0]  rows
);

  lptr_t sel_q, sel_d;
  logic  valid_q, valid_d;

  always_comb begin
    sel_d   = rd_go ? rd_ptr : sel_q;
    valid_d = rd_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      valid_q <= valid_d;
    end
  end

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    assign rows[t] = store_data[ptr_add(sel_q, t)];
  end

  assign rd_valid = valid_q;

endmodule

// File: rtl/rot_line_buf.sv
module rot_line_buf
  import rlb_pkg::*;
#(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned LINE_LEN = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wen,
  input  logic [PIX_W-1:0] wdata,
  input  logic             ren,
  output logic [PIX_W-1:0] row_top,
  output logic [PIX_W-1:0] row_mid,
  output logic [PIX_W-1:0] row_bot,
  output logic             rd_valid,
  output logic             lines_ready,
  output logic             all_read,
  output logic             wr_full
);

  logic rst_meta_q, rst_q;

  // asynchronous assert, clocked release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  lptr_t  wr_ptr, rd_ptr;
  occ_t   held;
  lmask_t wr_en_vec, rd_en_vec, rd_rst_vec, wr_last_vec, done_vec;
  logic   rd_go;
  logic [NLINES-1:0][PIX_W-1:0] store_data;
  logic [NTAPS-1:0][PIX_W-1:0]  rows;

  rlb_ptr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_q),
    .wen         (wen),
    .ren         (ren),
    .wr_last_vec (wr_last_vec),
    .done_vec    (done_vec),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .held        (held),
    .wr_en_vec   (wr_en_vec),
    .rd_en_vec   (rd_en_vec),
    .rd_rst_vec  (rd_rst_vec),
    .rd_go       (rd_go),
    .lines_ready (lines_ready),
    .wr_full     (wr_full),
    .all_read    (all_read)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    rlb_line_store #(
      .PIX_W (PIX_W),
      .DEPTH (LINE_LEN)
    ) u_store (
      .clk     (clk),
      .rst_n   (rst_q),
      .wr_en   (wr_en_vec[i]),
      .wr_data (wdata),
      .wr_last (wr_last_vec[i]),
      .rd_en   (rd_en_vec[i]),
      .rd_rst  (rd_rst_vec[i]),
      .rd_data (store_data[i]),
      .rd_done (done_vec[i])
    );
  end

  rlb_row_mux #(
    .PIX_W (PIX_W)
  ) u_mux (
    .clk        (clk),
    .rst_n      (rst_q),
    .rd_go      (rd_go),
    .rd_ptr     (rd_ptr),
    .store_data (store_data),
    .rd_valid   (rd_valid),
    .rows       (rows)
  );

  assign row_top = rows[0];
  assign row_mid = rows[1];
  assign row_bot = rows[2];

endmodule

// File: rtl/rlb_checker.sv
module rlb_checker
  import rlb_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  ren,
  input logic  rd_valid,
  input logic  lines_ready,
  input logic  all_read,
  input logic  wr_full,
  input lptr_t wr_ptr,
  input lptr_t rd_ptr,
  input occ_t  held
);

  AST_FULL_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |-> lines_ready); // R6

  AST_FULL_HOLDS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full && !all_read |=> $stable(wr_ptr)); // R6

  AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(ren && lines_ready && !all_read)); // R4

  AST_DONE_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    all_read && ren |=> !rd_valid); // R5

  AST_WINDOW_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    all_read && wr_full |=> !all_read && !wr_full && lines_ready); // R7

  AST_PTR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr == lptr_t'((32'(rd_ptr) + 32'(held)) % NLINES)); // R8

endmodule

bind rot_line_buf rlb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .ren         (ren),
  .rd_valid    (rd_valid),
  .lines_ready (lines_ready),
  .all_read    (all_read),
  .wr_full     (wr_full),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .held        (held)
);

// File: tb/tb_rot_line_buf.sv
module tb_rot_line_buf;

  localparam int CLK_P    = 10;
  localparam int LEN      = 8;
  localparam int PW       = 8;
  localparam int WATCHDOG = 100000;

  logic          clk;
  logic          rst_n;
  logic          wen;
  logic [PW-1:0] wdata;
  logic          ren;
  logic [PW-1:0] row_top, row_mid, row_bot;
  logic          rd_valid, lines_ready, all_read, wr_full;

  rot_line_buf #(.PIX_W(PW), .LINE_LEN(LEN)) dut (
    .clk(clk), .rst_n(rst_n), .wen(wen), .wdata(wdata), .ren(ren),
    .row_top(row_top), .row_mid(row_mid), .row_bot(row_bot),
    .rd_valid(rd_valid), .lines_ready(lines_ready),
    .all_read(all_read), .wr_full(wr_full)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // behavioural reference: every accepted pixel kept by stream position
  logic [PW-1:0] pix [$];
  int            done_lines, base, col;
  bit            m_valid;
  logic [PW-1:0] m_row [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      pix.delete();
      done_lines = 0;
      base       = 0;
      col        = 0;
      m_valid    = 1'b0;
    end else begin
      int held_n;
      bit rdy, full, allr;
      held_n  = done_lines - base;
      rdy     = held_n >= 3;
      full    = held_n == 4;
      allr    = (col == LEN);
      m_valid = 1'b0;
      if (ren && rdy && !allr) begin
        m_valid  = 1'b1;
        m_row[0] = pix[base*LEN + col];
        m_row[1] = pix[(base+1)*LEN + col];
        m_row[2] = pix[(base+2)*LEN + col];
        col++;
      end
      if (wen && !full) begin
        pix.push_back(wdata);
        if (pix.size() % LEN == 0) done_lines++;
      end
      if (allr && full) begin
        base++;
        col = 0;
      end
    end
  end

  int    vectors, fails, cyc;
  string ph;

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int  h;
    bit  e_rdy, e_full, e_all;
    h      = done_lines - base;
    e_rdy  = h >= 3;
    e_full = h == 4;
    e_all  = (col == LEN);
    chk(lines_ready == e_rdy, (ph == "R1") ? "R1" : "R3", lines_ready, e_rdy);
    chk(wr_full == e_full, (ph == "R1") ? "R1" : "R6", wr_full, e_full);
    chk(all_read == e_all, (ph == "R1") ? "R1" : "R5", all_read, e_all);
    chk(rd_valid == m_valid, ph, rd_valid, m_valid);
    if (m_valid && rd_valid) begin
      chk(row_top == m_row[0], ph, row_top, m_row[0]);
      chk(row_mid == m_row[1], ph, row_mid, m_row[1]);
      chk(row_bot == m_row[2], ph, row_bot, m_row[2]);
    end
  endtask

  task automatic step(bit w, bit r);
    @(negedge clk);
    compare();
    wen   = w;
    ren   = r;
    wdata = PW'($urandom);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wen   = 1'b0;
    ren   = 1'b0;
    ph    = "R1";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    vectors = 0;
    fails   = 0;
    cyc     = 0;
    rst_n   = 1'b0;
    wen     = 1'b0;
    ren     = 1'b0;
    wdata   = '0;
    ph      = "R1";

    // R1: reset state
    do_reset();

    // R9: reads before three lines exist are ignored
    ph = "R9";
    for (int i = 0; i < 2*LEN; i++) step(1'b1, 1'b1);

    // R2 / R3: fill until four lines are held
    ph = "R2";
    while ((done_lines - base) < 4) step(1'b1, 1'b0);

    // R6: writes while full are dropped
    ph = "R6";
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);

    // R5: read whole window, then extra reads are ignored
    ph = "R5";
    for (int i = 0; i < LEN + 1; i++) step(1'b0, 1'b1);
    ph = "R7";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);

    // R7: carried-over lines read again without rewriting
    for (int i = 0; i < LEN + 4; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 2*LEN; i++) step(1'b1, 1'b0);
    for (int i = 0; i < LEN + 4; i++) step(1'b0, 1'b1);

    // R8: long random streaming across many pointer wraps
    ph = "R8";
    for (int i = 0; i < 1500; i++) step(($urandom % 10) < 7, ($urandom % 10) < 6);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1);

    // R2: concurrent write and read with sparse writes
    ph = "R2";
    for (int i = 0; i < 400; i++) step(($urandom % 4) == 0, 1'b1);

    // R1: reset in the middle of activity, then restart
    do_reset();
    ph = "R8";
    for (int i = 0; i < 600; i++) step(($urandom % 10) < 8, ($urandom % 2) == 0);

    step(1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule